// File: doc/BRIEF.md
# Segmented Fetch Address Generator

This block forms the 20-bit physical addresses used by a processor whose registers are 16 bits wide. It holds four 16-bit segment registers and a 16-bit instruction pointer. A physical address is the segment value shifted left by four bit positions, plus a 16-bit offset. The sum wraps within the 20-bit space.

The fetch side always pairs the code segment with the instruction pointer. The pointer steps by one on each accepted fetch. A far load replaces the code segment and the pointer together in one cycle, so execution can move to any 64 KB window. After reset the fetch address is FFFF0h, sixteen bytes below the top of the space, so a far load is normally the first action.

A separate data-access port pairs any of the four segments with an offset and returns the address combinationally. The three segments other than code are written through a register-write port.

Top module: `seg_fetch_agu`

## Requirements
- R1: `fetch_addr` equals (code segment × 16 + instruction pointer) modulo 2^20, and reflects the registered state.
- R2: Address formation wraps modulo 2^20. For example, segment FFFFh with offset 0010h gives 00000h.
- R3: While `rst_n` is low, the registers take their reset values: code segment FFFFh, instruction pointer 0000h, and the other three segments 0000h. `fetch_addr` is then FFFF0h.
- R4: Each cycle with `fetch_ack` high and `far_ld` low adds one to the instruction pointer at the next clock edge. With `fetch_ack` low the pointer holds.
- R5: The instruction pointer wraps from FFFFh to 0000h on a fetch. The code segment stays unchanged.
- R6: A cycle with `far_ld` high loads `far_cs` into the code segment and `far_ip` into the instruction pointer at the next edge.
- R7: When `far_ld` and `fetch_ack` are both high, the far load wins. The pointer becomes `far_ip`, not an incremented value.
- R8: `data_addr` = (segment[`data_sel`] × 16 + `data_off`) modulo 2^20, combinationally. The select encoding is 0 = code, 1 = stack, 2 = data, 3 = extra.
- R9: With `seg_wr_en` high and `seg_wr_sel` set to 1, 2 or 3, that segment takes `seg_wr_data` at the next edge. The same 0–3 encoding as R8 applies.
- R10: A register write with `seg_wr_sel` = 0 is ignored. The code segment changes only through reset or a far load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_ack | input | 1 | Fetch accepted; advance the pointer |
| far_ld | input | 1 | Load code segment and pointer together |
| far_cs | input | 16 | New code segment for a far load |
| far_ip | input | 16 | New instruction pointer for a far load |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment to write (0 is ignored) |
| seg_wr_data | input | 16 | Value to write |
| data_sel | input | 2 | Segment used by the data port |
| data_off | input | 16 | Offset for the data port |
| fetch_addr | output | 20 | Physical fetch address |
| data_addr | output | 20 | Physical data-access address |
| code_seg | output | 16 | Current code segment |
| instr_ptr | output | 16 | Current instruction pointer |

## Verification
The bench targets several corner cases:
- **Reset vector.** A wrong reset value or a wrong shift direction shows up as a first fetch address other than FFFF0h.
- **Address carry.** Segment FFFFh with a small offset must wrap to zero. A design that keeps a 21st bit or saturates gives a large address instead.
- **Pointer rollover.** The pointer must roll from FFFFh to 0000h. A design that carries into the code segment would move the fetch window.
- **Far load with a fetch.** When both arrive in one cycle, a design that gives the fetch priority ends one past the jump target.
- **Write to the code select.** A register write naming the code segment must leave it untouched. A design that accepts it would redirect fetches without a far load.

Random traffic compared against a reference model on every cycle covers the remaining select and offset patterns.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int PA_W    = SEG_W + SHIFT;
  localparam int NUM_SEG = 4;
  localparam int SEL_W   = $clog2(NUM_SEG);

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [OFF_W-1:0] off_t;
  typedef logic [PA_W-1:0]  paddr_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_CODE  = 2'd0,
    SEL_STACK = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_EXTRA = 2'd3
  } seg_sel_e;

  // Segment base shifted left by SHIFT bits, plus the offset.
  // The sum is truncated to PA_W bits, so it wraps modulo 2^PA_W.
  function automatic paddr_t form_paddr(seg_t s, off_t o);
    paddr_t base;
    paddr_t ext;
    base = {s, {SHIFT{1'b0}}};
    ext  = PA_W'(o);
    return base + ext;
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_agu_pkg::*;
#(
  parameter seg_t RESET_CS = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             far_ld,
  input  seg_t             far_cs,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  seg_t             wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output seg_t             code_seg,
  output seg_t             rd_seg
);
  seg_t             seg_q  [NUM_SEG];
  logic [NUM_SEG-1:0] wr_hit;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    if (g == int'(SEL_CODE)) begin : g_code
      // The code segment is loaded only by a far load.
      assign wr_hit[g] = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seg_q[g] <= RESET_CS;
        else if (far_ld) seg_q[g] <= far_cs;
      end
    end else begin : g_other
      assign wr_hit[g] = wr_en && (wr_sel == SEL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seg_q[g] <= '0;
        else if (wr_hit[g]) seg_q[g] <= wr_data;
      end
    end
  end

  assign code_seg = seg_q[int'(SEL_CODE)];
  assign rd_seg   = seg_q[rd_sel];

  // R9: a write to a non-code segment lands at the next edge.
  a_r9_seg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != SEL_CODE) |=> seg_q[$past(wr_sel)] == $past(wr_data));

  // R10: without a far load the code segment holds.
  a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !far_ld |=> $stable(code_seg));

  // R10: the write decode never selects the code segment.
  a_r10_no_code_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[int'(SEL_CODE)] && $onehot0(wr_hit));
endmodule

// File: rtl/ip_counter.sv
module ip_counter
  import seg_agu_pkg::*;
#(
  parameter off_t RESET_IP = 16'h0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic far_ld,
  input  off_t far_ip,
  input  logic step,
  output off_t ip,
  output logic wrap_evt
);
  off_t ip_q;
  logic step_take;

  // A far load takes priority over a fetch step.
  assign step_take = step && !far_ld;
  assign wrap_evt  = step_take && (ip_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ip_q <= RESET_IP;
    else if (far_ld)    ip_q <= far_ip;
    else if (step_take) ip_q <= ip_q + off_t'(1);
  end

  assign ip = ip_q;

  // R4: an accepted fetch adds one to the pointer.
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !far_ld) |=> ip == off_t'($past(ip) + off_t'(1)));

  // R4: with no fetch and no far load the pointer holds.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !far_ld) |=> $stable(ip));

  // R5: a fetch at FFFFh rolls the pointer to zero.
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ip == '0);

  // R6: a far load places far_ip in the pointer.
  a_r6_far_ip: assert property (@(posedge clk) disable iff (!rst_n)
    far_ld |=> ip == $past(far_ip));

  // R7: a far load that arrives with a fetch still wins.
  a_r7_far_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (far_ld && step) |=> ip == $past(far_ip));
endmodule

// File: rtl/paddr_unit.sv
module paddr_unit
  import seg_agu_pkg::*;
(
  input  seg_t   seg,
  input  off_t   off,
  output paddr_t paddr
);
  assign paddr = form_paddr(seg, off);
endmodule

// File: rtl/seg_fetch_agu.sv
module seg_fetch_agu
  import seg_agu_pkg::*;
#(
  parameter logic [15:0] RESET_CS = 16'hFFFF,
  parameter logic [15:0] RESET_IP = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_ack,
  input  logic        far_ld,
  input  logic [15:0] far_cs,
  input  logic [15:0] far_ip,
  input  logic        seg_wr_en,
  input  logic [1:0]  seg_wr_sel,
  input  logic [15:0] seg_wr_data,
  input  logic [1:0]  data_sel,
  input  logic [15:0] data_off,
  output logic [19:0] fetch_addr,
  output logic [19:0] data_addr,
  output logic [15:0] code_seg,
  output logic [15:0] instr_ptr
);
  seg_t rd_seg;
  logic ip_wrap;

  seg_regfile #(.RESET_CS(RESET_CS)) i_segs (
    .clk      (clk),
    .rst_n    (rst_n),
    .far_ld   (far_ld),
    .far_cs   (far_cs),
    .wr_en    (seg_wr_en),
    .wr_sel   (seg_wr_sel),
    .wr_data  (seg_wr_data),
    .rd_sel   (data_sel),
    .code_seg (code_seg),
    .rd_seg   (rd_seg)
  );

  ip_counter #(.RESET_IP(RESET_IP)) i_ip (
    .clk      (clk),
    .rst_n    (rst_n),
    .far_ld   (far_ld),
    .far_ip   (far_ip),
    .step     (fetch_ack),
    .ip       (instr_ptr),
    .wrap_evt (ip_wrap)
  );

  paddr_unit i_fetch_pa (.seg(code_seg), .off(instr_ptr), .paddr(fetch_addr));
  paddr_unit i_data_pa  (.seg(rd_seg),   .off(data_off),  .paddr(data_addr));

  // R1: the offset occupies the low nibble unchanged.
  a_r1_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[SHIFT-1:0] == instr_ptr[SHIFT-1:0]);

  // R3: on the first edge after reset the fetch address is the reset vector.
  a_r3_reset_vector: assert property (@(posedge clk)
    $rose(rst_n) |-> (code_seg == RESET_CS && instr_ptr == RESET_IP));

  // R5: a pointer rollover leaves the code segment in place.
  a_r5_cs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ip_wrap |=> $stable(code_seg));

  // R6: a far load places far_cs in the code segment.
  a_r6_far_cs: assert property (@(posedge clk) disable iff (!rst_n)
    far_ld |=> code_seg == $past(far_cs));

  // R8: the data port with the code select agrees with the fetch path.
  a_r8_data_code: assert property (@(posedge clk) disable iff (!rst_n)
    (data_sel == SEL_CODE && data_off == instr_ptr) |-> data_addr == fetch_addr);
endmodule

// File: tb/test_seg_fetch_agu.sv
module test_seg_fetch_agu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_ack = 1'b0, far_ld = 1'b0, seg_wr_en = 1'b0;
  logic [15:0] far_cs = '0, far_ip = '0, seg_wr_data = '0, data_off = '0;
  logic [1:0]  seg_wr_sel = '0, data_sel = '0;
  logic [19:0] fetch_addr, data_addr;
  logic [15:0] code_seg, instr_ptr;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R3";

  // Reference model state.
  int  m_seg [4];
  int  m_ip;
  bit  model_ok = 0;

  seg_fetch_agu i_seg_fetch_agu (
    .clk(clk), .rst_n(rst_n), .fetch_ack(fetch_ack), .far_ld(far_ld),
    .far_cs(far_cs), .far_ip(far_ip), .seg_wr_en(seg_wr_en),
    .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data), .data_sel(data_sel),
    .data_off(data_off), .fetch_addr(fetch_addr), .data_addr(data_addr),
    .code_seg(code_seg), .instr_ptr(instr_ptr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_pa(int s, int o);
    return (s * 16 + o) % 1048576;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%05h expected=%05h", req, what, act, exp);
    end
  endtask

  // The model advances on each rising edge from the inputs held since the last edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_seg[0] = 'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
      m_ip = 0;
      model_ok = 1;
    end else if (model_ok) begin
      if (far_ld) begin
        m_seg[0] = int'(far_cs);
        m_ip = int'(far_ip);
      end else if (fetch_ack) begin
        m_ip = (m_ip + 1) % 65536;
      end
      if (seg_wr_en && seg_wr_sel != 2'd0) m_seg[seg_wr_sel] = int'(seg_wr_data);
    end
  end

  // Full comparison on every falling edge.
  always @(negedge clk) begin
    if (rst_n && model_ok) begin
      chk(cur_req, int'(fetch_addr), ref_pa(m_seg[0], m_ip), "fetch_addr (R1)");
      chk(cur_req, int'(code_seg), m_seg[0], "code_seg");
      chk(cur_req, int'(instr_ptr), m_ip, "instr_ptr");
      chk(cur_req, int'(data_addr), ref_pa(m_seg[data_sel], int'(data_off)), "data_addr (R8)");
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    fetch_ack = 0; far_ld = 0; seg_wr_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R3: reset state
    cur_req = "R3";
    #1;
    chk("R3", int'(fetch_addr), 'hFFFF0, "reset fetch_addr");
    chk("R3", int'(code_seg), 'hFFFF, "reset code_seg");
    chk("R3", int'(instr_ptr), 0, "reset instr_ptr");
    data_sel = 2'd3; data_off = 16'h0000; #1;
    chk("R3", int'(data_addr), 0, "reset extra segment");

    // R6: far load
    cur_req = "R6";
    tick(); far_ld = 1; far_cs = 16'hF000; far_ip = 16'hC000;
    tick(); idle();
    chk("R6", int'(fetch_addr), 'hFC000, "far load target");

    // R4: sequential fetches
    cur_req = "R4";
    fetch_ack = 1;
    repeat (5) tick();
    idle();
    chk("R4", int'(instr_ptr), 'hC005, "five fetches");
    tick();
    chk("R4", int'(instr_ptr), 'hC005, "hold without ack");

    // R7: far load wins over a fetch
    cur_req = "R7";
    far_ld = 1; fetch_ack = 1; far_cs = 16'h1234; far_ip = 16'h5678;
    tick(); idle();
    chk("R7", int'(instr_ptr), 'h5678, "far beats fetch");
    chk("R7", int'(fetch_addr), 'h179B8, "far beats fetch addr");

    // R5: pointer wrap
    cur_req = "R5";
    far_ld = 1; far_cs = 16'h0100; far_ip = 16'hFFFE;
    tick(); idle();
    fetch_ack = 1;
    repeat (3) tick();
    idle();
    chk("R5", int'(instr_ptr), 1, "ip after wrap");
    chk("R5", int'(code_seg), 'h0100, "cs kept on wrap");

    // R9 / R2: stack segment write then wrap of address
    cur_req = "R9";
    seg_wr_en = 1; seg_wr_sel = 2'd1; seg_wr_data = 16'hFFFF;
    tick(); idle();
    cur_req = "R2";
    data_sel = 2'd1; data_off = 16'h0010; #1;
    chk("R2", int'(data_addr), 'h00000, "FFFF:0010 wraps");

    // R9 / R8: data and extra segments
    cur_req = "R9";
    seg_wr_en = 1; seg_wr_sel = 2'd2; seg_wr_data = 16'h2000;
    tick();
    seg_wr_sel = 2'd3; seg_wr_data = 16'hABCD;
    tick(); idle();
    cur_req = "R8";
    data_sel = 2'd2; data_off = 16'h0123; #1;
    chk("R8", int'(data_addr), 'h20123, "data segment select");
    data_sel = 2'd3; data_off = 16'h0004; #1;
    chk("R8", int'(data_addr), 'hABCD4, "extra segment select");

    // R10: write aimed at the code segment is ignored
    cur_req = "R10";
    seg_wr_en = 1; seg_wr_sel = 2'd0; seg_wr_data = 16'h5555;
    tick(); idle();
    chk("R10", int'(code_seg), 'h0100, "code write ignored");
    data_sel = 2'd0; data_off = instr_ptr; #1;
    chk("R10", int'(data_addr), 'h01001, "code select via data port");

    // R1: random traffic against the model
    cur_req = "R1";
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #2;
      fetch_ack   = $urandom_range(0, 1) == 1;
      far_ld      = $urandom_range(0, 7) == 0;
      far_cs      = 16'($urandom);
      far_ip      = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      seg_wr_en   = $urandom_range(0, 3) == 0;
      seg_wr_sel  = 2'($urandom);
      seg_wr_data = 16'($urandom);
      data_sel    = 2'($urandom);
      data_off    = 16'($urandom);
    end
    idle();
    tick(); tick();

    summary();
    $finish;
  end
endmodule